// File: doc/BRIEF.md
# Dual-Framing Three-Lane Serial Word Receiver

The block recovers a 21-bit parallel word from three serial data lanes. It samples them on a bit-rate clock that comes from outside the block. A parallel-rate frame clock travels with the lanes, and its rising edge marks the first bit of every frame. A static mode input selects one of two framings. In plain framing each lane carries 7 bits per frame. In balanced framing each lane carries 9 bits per frame: an inversion flag, a spare control bit, and 7 data bits. The receiver undoes the inversion, so the output always shows the data word the sender started with.

The outputs are gated in two ways. An active-low power-down input puts every data output and the output strobe into high impedance. A lock-wait counter keeps the outputs at zero until a set number of frames has completed since reset, since the last power-down, or since the last change of framing mode. The output strobe shows the frame rhythm. A parameter sets whether the data is meant to be captured on its rising edge or on its falling edge.

Top module: `desdc_deser`

## Requirements
- R1: Lane k drives output bits 7k+6 down to 7k. The first data bit a lane delivers in a frame appears on bit 7k+6, and the last one on bit 7k.
- R2: With `dcb_mode`=0 a frame is 7 bits per lane, sent most significant first. The decoded word appears on `dout` in the bit-clock cycle right after the edge that samples the frame's last bit.
- R3: With `dcb_mode`=1 a frame is 9 bits per lane. The first bit is an inversion flag, the second is ignored, and the last 7 are data. When the flag is 1 the data bits are complemented before output. A lane's running sum (+1 for each one, -1 for each zero) then stays within ±10.
- R4: A bit-clock edge that samples `fclk_in` high, after sampling it low at the previous edge, takes in bit 0 of a new frame. Idle bits between frames do not shift the frame alignment.
- R5: While `pwr_n` is 0, `dout` and `clk_out` are high impedance.
- R6: With `pwr_n` high, `dout` and `clk_out` stay 0 until LOCK_FRAMES frames have completed since the last restart. After that they carry the live word and strobe.
- R7: A power-down, or a change of `dcb_mode`, seen at a clock edge restarts the lock wait from zero.
- R8: With STROBE_FALL=0, `clk_out` goes low at the edge where a new word is output. It goes high at the edge whose next bit index is half the frame length (3 for plain framing, 4 for balanced).
- R9: With STROBE_FALL=1, `clk_out` is the complement of the R8 waveform whenever the block is locked and powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; tri-states the outputs |
| dcb_mode | input | 1 | 1 = 9-bit balanced framing, 0 = 7-bit plain framing |
| fclk_in | input | 1 | Parallel-rate frame clock; its rising edge starts a frame |
| lane_in | input | 3 | Serial data lanes, one bit each |
| dout | output | 21 | Recovered parallel word, grouped by lane |
| clk_out | output | 1 | Parallel-rate output strobe |

## Verification
The hardest state to reach is balanced framing in which the inversion flag and the spare bit both take each value. The sender still has to keep every lane's running sum inside ±10, or the balance monitor would fire. The bench has its own encoder. For every word it tries the four settings of the control bits in a randomly chosen order, and it keeps the first setting that holds both the running sum within the word and the sum at the word's end inside the bound. The lock restart is reached with mid-stream mode changes and power-down. Realignment is reached with idle gaps between plain frames.

// File: rtl/desdc_pkg.sv
package desdc_pkg;

  localparam int unsigned DEF_LANES  = 3;
  localparam int unsigned DEF_DATA_W = 7;
  localparam int unsigned DEF_CTRL_W = 2;

  // Index of the final bit in a frame for the selected framing.
  function automatic int unsigned last_bit_index(input logic bal,
                                                 input int unsigned data_w,
                                                 input int unsigned ctrl_w);
    return bal ? (data_w + ctrl_w - 1) : (data_w - 1);
  endfunction

  // Bit index at which the output strobe rises (half the frame length).
  function automatic int unsigned strobe_rise_index(input logic bal,
                                                    input int unsigned data_w,
                                                    input int unsigned ctrl_w);
    return bal ? ((data_w + ctrl_w) / 2) : (data_w / 2);
  endfunction

endpackage

// File: rtl/desdc_bit_timer.sv
module desdc_bit_timer
  import desdc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CTRL_W = DEF_CTRL_W,
  parameter int unsigned CNT_W  = $clog2(DATA_W + CTRL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bal,
  input  logic             fclk_in,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_start,
  output logic             frame_end,
  output logic             strobe_q
);

  logic             fclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] rise_idx;
  logic [CNT_W-1:0] next_idx;

  assign last_idx    = CNT_W'(last_bit_index(bal, DATA_W, CTRL_W));
  assign rise_idx    = CNT_W'(strobe_rise_index(bal, DATA_W, CTRL_W));
  assign frame_start = fclk_in & ~fclk_q;
  assign bit_idx     = frame_start ? '0 : cnt_q;
  assign frame_end   = (bit_idx == last_idx);
  assign next_idx    = (bit_idx >= last_idx) ? '0 : bit_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q   <= 1'b0;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      fclk_q   <= fclk_in;
      cnt_q    <= next_idx;
      strobe_q <= (next_idx >= rise_idx);
    end
  end

endmodule

// File: rtl/desdc_lane.sv
module desdc_lane
  import desdc_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CTRL_W = DEF_CTRL_W,
  localparam int unsigned RAW_W = DATA_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bal,
  input  logic              sdi,
  input  logic              frame_end,
  output logic [DATA_W-1:0] word_q
);

  logic [RAW_W-2:0] shift_q;
  logic [RAW_W-1:0] raw;

  // Inversion flag is the first bit of a balanced frame; the spare bit is dropped.
  function automatic logic [DATA_W-1:0] decode_word(input logic [RAW_W-1:0] r,
                                                    input logic b);
    logic [DATA_W-1:0] d;
    d = r[DATA_W-1:0];
    if (b && r[RAW_W-1]) d = ~d;
    return d;
  endfunction

  assign raw = {shift_q, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      word_q  <= '0;
    end else begin
      shift_q <= raw[RAW_W-2:0];
      if (frame_end) word_q <= decode_word(raw, bal);
    end
  end

endmodule

// File: rtl/desdc_lock.sv
module desdc_lock #(
  parameter int unsigned LOCK_FRAMES = 32800,
  localparam int unsigned CW = $clog2(LOCK_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic frame_end,
  output logic locked
);

  logic [CW-1:0] count_q;

  assign locked = (count_q == CW'(LOCK_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count_q <= '0;
    else if (restart)            count_q <= '0;
    else if (frame_end && !locked) count_q <= count_q + 1'b1;
  end

endmodule

// File: rtl/desdc_deser.sv
module desdc_deser
  import desdc_pkg::*;
#(
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned CTRL_W      = DEF_CTRL_W,
  parameter int unsigned LOCK_FRAMES = 32800,
  parameter bit          STROBE_FALL = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_n,
  input  logic                    dcb_mode,
  input  logic                    fclk_in,
  input  logic [LANES-1:0]        lane_in,
  output logic [LANES*DATA_W-1:0] dout,
  output logic                    clk_out
);

  localparam int unsigned OUT_W = LANES * DATA_W;
  localparam int unsigned CNT_W = $clog2(DATA_W + CTRL_W);

  logic             mode_q;
  logic             mode_chg;
  logic             restart;
  logic             locked;
  logic             frame_start;
  logic             frame_end;
  logic             strobe_q;
  logic [CNT_W-1:0] bit_idx;
  logic [OUT_W-1:0] word_all;
  logic [OUT_W-1:0] dout_live;
  logic             strobe_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= dcb_mode;
  end

  assign mode_chg = (dcb_mode != mode_q);
  assign restart  = ~pwr_n | mode_chg;

  desdc_bit_timer #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bal(dcb_mode), .fclk_in(fclk_in),
    .bit_idx(bit_idx), .frame_start(frame_start), .frame_end(frame_end),
    .strobe_q(strobe_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    desdc_lane #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .bal(dcb_mode), .sdi(lane_in[g]),
      .frame_end(frame_end), .word_q(word_all[g*DATA_W +: DATA_W])
    );
  end

  desdc_lock #(.LOCK_FRAMES(LOCK_FRAMES)) u_lock (
    .clk(clk), .rst_n(rst_n), .restart(restart), .frame_end(frame_end),
    .locked(locked)
  );

  assign dout_live   = locked ? word_all : '0;
  assign strobe_live = locked & (strobe_q ^ STROBE_FALL);

  assign dout    = pwr_n ? dout_live   : {OUT_W{1'bz}};
  assign clk_out = pwr_n ? strobe_live : 1'bz;

endmodule

// File: rtl/desdc_deser_chk.sv
module desdc_deser_chk #(
  parameter int unsigned LANES = 3,
  parameter int unsigned OUT_W = 21,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_n,
  input logic             dcb_mode,
  input logic [LANES-1:0] lane_in,
  input logic [OUT_W-1:0] dout,
  input logic             clk_out,
  input logic             locked,
  input logic             frame_end,
  input logic             mode_chg,
  input logic             strobe_q,
  input logic [CNT_W-1:0] bit_idx
);

  // Running-sum monitor for balanced framing, one per lane.
  int dsv_q [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < LANES; i++) begin
      if (!rst_n || !dcb_mode) dsv_q[i] <= 0;
      else                     dsv_q[i] <= dsv_q[i] + (lane_in[i] ? 1 : -1);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_dsv
    p_dsv_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dsv_q[g] <= 10) && (dsv_q[g] >= -10));
  end

  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bit_idx == '0));

  p_zero_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && !locked) |-> (dout == '0) && (clk_out == 1'b0));

  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pwr_n && !mode_chg) |=> locked);

  p_pwr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !locked);

  p_mode_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !locked);

  p_strobe_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !strobe_q);

endmodule

bind desdc_deser desdc_deser_chk #(
  .LANES(LANES), .OUT_W(LANES*DATA_W), .CNT_W($clog2(DATA_W + CTRL_W))
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .dcb_mode(dcb_mode),
  .lane_in(lane_in), .dout(dout), .clk_out(clk_out), .locked(locked),
  .frame_end(frame_end), .mode_chg(mode_chg), .strobe_q(strobe_q),
  .bit_idx(bit_idx)
);

// File: tb/desdc_deser_tb.sv
`timescale 1ns/1ps
module desdc_deser_tb;

  localparam int LOCK = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_n = 1'b1;
  logic        dcb_mode = 1'b0;
  logic        fclk_in = 1'b0;
  logic [2:0]  lane_in = '0;
  logic [20:0] dout, dout_f;
  logic        clk_out, clk_out_f;

  always #10 clk = ~clk;

  desdc_deser #(.LOCK_FRAMES(LOCK), .STROBE_FALL(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .dcb_mode(dcb_mode),
    .fclk_in(fclk_in), .lane_in(lane_in), .dout(dout), .clk_out(clk_out));

  desdc_deser #(.LOCK_FRAMES(LOCK), .STROBE_FALL(1'b1)) u_dut_f (
    .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .dcb_mode(dcb_mode),
    .fclk_in(fclk_in), .lane_in(lane_in), .dout(dout_f), .clk_out(clk_out_f));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R6";

  // bench-side driven values and reference model state
  logic        b_pwr = 1'b1, b_mode = 1'b0;
  logic        m_pwr = 1'b1, m_mode_prev = 1'b0, m_fprev = 1'b0, m_strobe = 1'b0;
  int          m_cnt = 0, m_lock = 0;
  logic [20:0] m_word = '0;
  int          enc_s [3];

  task automatic check(input bit ok, input string t, input logic [20:0] act,
                       input logic [20:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [20:0] ed;
    logic        ec, ecf;
    if (!m_pwr) begin
      ed = {21{1'bz}}; ec = 1'bz; ecf = 1'bz;
    end else if (m_lock >= LOCK) begin
      ed = m_word; ec = m_strobe; ecf = ~m_strobe;
    end else begin
      ed = '0; ec = 1'b0; ecf = 1'b0;
    end
    check(dout === ed, tag, dout, ed);
    check(clk_out === ec, "R8 strobe", {20'd0, clk_out}, {20'd0, ec});
    check(clk_out_f === ecf, "R9 strobe", {20'd0, clk_out_f}, {20'd0, ecf});
  endtask

  task automatic tick(input logic [2:0] bits, input logic fc, input bit last,
                      input logic [20:0] word);
    int n, idx, nxt;
    bit restart;
    compare_all();
    lane_in = bits; fclk_in = fc; pwr_n = b_pwr; dcb_mode = b_mode;
    m_pwr = b_pwr;
    @(posedge clk);
    n = b_mode ? 9 : 7;
    idx = (fc && !m_fprev) ? 0 : m_cnt;
    m_fprev = fc;
    nxt = (idx >= n - 1) ? 0 : idx + 1;
    m_cnt = nxt;
    m_strobe = (nxt >= n / 2);
    if (last) m_word = word;
    restart = !b_pwr || (b_mode != m_mode_prev);
    m_mode_prev = b_mode;
    if (restart) m_lock = 0;
    else if (last && m_lock < LOCK) m_lock++;
    @(negedge clk);
  endtask

  // Balanced encoder: choose control bits keeping the running sum bounded.
  function automatic logic [8:0] encode(input logic [6:0] d, inout int s,
                                        input int unsigned pref);
    for (int k = 0; k < 4; k++) begin
      logic inv, sp;
      logic [8:0] w;
      int t, pk;
      inv = logic'((k >> 1) & 1) ^ logic'(pref & 1);
      sp  = logic'(k & 1) ^ logic'((pref >> 1) & 1);
      w = {inv, sp, inv ? ~d : d};
      t = s; pk = 0;
      for (int i = 8; i >= 0; i--) begin
        t += w[i] ? 1 : -1;
        if (t > pk) pk = t;
        if (-t > pk) pk = -t;
      end
      if (pk <= 10 && t <= 7 && t >= -7) begin
        s = t;
        return w;
      end
    end
    return {2'b01, d};
  endfunction

  task automatic send_frame(input logic [20:0] data, input int gap);
    logic [8:0] raw [3];
    int n;
    for (int g = 0; g < gap; g++) tick(3'b000, 1'b0, 1'b0, '0);
    n = b_mode ? 9 : 7;
    for (int l = 0; l < 3; l++) begin
      if (b_mode) raw[l] = encode(data[7*l +: 7], enc_s[l], $urandom);
      else        raw[l] = {2'b00, data[7*l +: 7]};
    end
    for (int b = 0; b < n; b++) begin
      logic [2:0] bits;
      for (int l = 0; l < 3; l++) bits[l] = raw[l][n-1-b];
      tick(bits, logic'(b < (n + 1) / 2), b == n - 1, data);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state is zero while powered
    check(dout === '0, "R6 reset", dout, '0);
    check(clk_out === 1'b0, "R6 reset strobe", {20'd0, clk_out}, '0);

    // R2: plain framing, lock builds up over the first frames
    tag = "R2";
    for (int i = 0; i < LOCK + 4; i++) send_frame(21'($urandom), 0);

    // R1: lane grouping and bit order
    tag = "R1";
    send_frame(21'h000040, 0);
    check(dout === 21'h000040, "R1 lane0 first bit", dout, 21'h000040);
    send_frame(21'h100000, 0);
    check(dout === 21'h100000, "R1 lane2 first bit", dout, 21'h100000);
    send_frame(21'h000081, 0);
    check(dout === 21'h000081, "R1 lane0 last and lane1 last", dout, 21'h000081);

    // R4: idle gaps between frames must not move the alignment
    tag = "R4";
    for (int i = 0; i < 6; i++) send_frame(21'($urandom), 1 + (i % 3));

    // R5: power-down tri-states; R7: lock restarts after it
    tag = "R5";
    b_pwr = 1'b0;
    for (int i = 0; i < 2; i++) send_frame(21'($urandom), 0);
    b_pwr = 1'b1;
    tag = "R7";
    for (int i = 0; i < LOCK + 3; i++) send_frame(21'($urandom), 0);

    // R3: balanced framing with inversion flag and spare bit varied
    tag = "R3";
    b_mode = 1'b1;
    for (int l = 0; l < 3; l++) enc_s[l] = 0;
    for (int i = 0; i < LOCK + 24; i++) send_frame(21'($urandom), 0);
    send_frame(21'h1FFFFF, 0);
    check(dout === 21'h1FFFFF, "R3 all ones decoded", dout, 21'h1FFFFF);
    send_frame(21'h000000, 0);
    check(dout === 21'h000000, "R3 all zeros decoded", dout, 21'h000000);

    // R7: mode change back to plain restarts the lock wait
    tag = "R7";
    b_mode = 1'b0;
    send_frame(21'h0ABCDE, 0);
    check(dout === '0, "R7 held after mode change", dout, '0);
    for (int i = 0; i < LOCK + 3; i++) send_frame(21'($urandom), 0);

    compare_all();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule